// File: doc/BRIEF.md
# Palette Loader and Colour Converter

This block receives the colour-table words that arrive from a palette-type frame and turns each word into a 24-bit RGB colour with a one-bit transparency flag. The converted colours go into a lookup table indexed by entry number, and a pixel pipeline reads a colour back through a one-cycle lookup port. The pixel depth fixes how many entries one load accepts. A two-bit format selector picks how the red, green, blue and transparency fields sit in each incoming word. A monochrome input overrides the format and spreads the low byte of the word over all three channels.

The unconverted words are also kept in a second table. When the format selector changes, the block converts every stored word again with the new format, one entry per clock, without a new fetch. A busy output is high while this sweep runs. While busy is high, incoming words and load starts are dropped.

Top module: `clut_loader`

## Requirements
- R1: During and after synchronous reset, `busy`, `lk_rgb` and `lk_trans` are 0.
- R2: A load started with `depth` 1, 2 or 3 accepts 4, 16 or 256 entries. Any other depth code accepts none. Words beyond the accepted count are dropped and leave the table unchanged.
- R3: Format 0 takes red from bits 15:11, green from 10:5 and blue from 4:0, each placed in the top bits of its 8-bit channel with zeros below. Transparency is 0.
- R4: Format 1 uses the same colour fields as format 0, and transparency equals bit 24.
- R5: Format 2 takes red from bits 23:19, green from 15:10 and blue from 7:3, each placed in the top bits with zeros below. Transparency equals bit 24.
- R6: Format 3 takes red from bits 23:16, green from 15:8 and blue from 7:0. Transparency equals bit 24.
- R7: When `mono` is 1, all three channels equal bits 7:0 of the word, whatever the format. Transparency still follows the format.
- R8: `lk_rgb` = {red, green, blue} and `lk_trans` show the entry `lk_idx` addressed at the previous clock edge, as stored before that edge. A write at that same edge is not yet visible.
- R9: A sweep starts at a clock edge where `busy`, `in_valid` and `load_start` are low and `fmt` differs from the format last applied. It reconverts the N stored entries with the new format, and `busy` stays high for exactly N+1 cycles. With N = 0 the new format is recorded and `busy` stays low.
- R10: While `busy` is high, `in_valid` and `load_start` are ignored.
- R11: An accepted `load_start` restarts the entry index at 0. A `load_start` that coincides with `in_valid` takes precedence, and that word is dropped. Each accepted word is stored at the next index in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_start | input | 1 | Begin a new table load; samples `depth` |
| depth | input | 4 | Pixel depth code: 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp |
| fmt | input | 2 | Entry format selector 0..3 |
| mono | input | 1 | Monochrome override |
| in_valid | input | 1 | `in_entry` carries a table word this cycle |
| in_entry | input | 32 | Raw table word |
| lk_idx | input | IDX_W | Lookup index |
| lk_rgb | output | 24 | Converted colour {R, G, B} |
| lk_trans | output | 1 | Converted transparency flag |
| busy | output | 1 | Reconversion sweep in progress |

## Verification
The bench builds the block with the default `IDX_W` of 8. This allows a full 256-entry load and a full-table reconversion alongside the 4- and 16-entry loads. At this size it can show that a 2 bpp load leaves entries 4 and up untouched from an earlier 8 bpp load. It can also show that a sweep over 16 entries holds busy for 17 cycles, and that a format change with an empty table raises no busy. Lookups that address the entry being written in the same cycle exercise the read-before-write latency, and words and load starts driven during a sweep show that they are dropped.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef struct packed {
    logic       trans;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } clut_color_t;

  localparam int COLOR_W = $bits(clut_color_t);

  // entries accepted per load for a depth code (0 = not a palette depth)
  function automatic int clut_entries(input logic [3:0] depth);
    case (depth)
      4'd1:    return 4;
      4'd2:    return 16;
      4'd3:    return 256;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/clut_ram.sv
module clut_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // read-first registered output, resettable output register
  always_ff @(posedge clk) begin
    if (rst)     rq <= '0;
    else if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/clut_convert.sv
module clut_convert
  import clut_pkg::*;
(
  input  logic [31:0]  entry,
  input  logic [1:0]   fmt,
  input  logic         mono,
  output clut_color_t  color
);
  logic unused_hi_bits;
  assign unused_hi_bits = ^entry[31:25];

  always_comb begin
    color.trans = (fmt == 2'd0) ? 1'b0 : entry[24];
    case (fmt)
      2'd2: begin
        color.r = {entry[23:19], 3'b000};
        color.g = {entry[15:10], 2'b00};
        color.b = {entry[7:3],   3'b000};
      end
      2'd3: begin
        color.r = entry[23:16];
        color.g = entry[15:8];
        color.b = entry[7:0];
      end
      default: begin
        color.r = {entry[15:11], 3'b000};
        color.g = {entry[10:5],  2'b00};
        color.b = {entry[4:0],   3'b000};
      end
    endcase
    if (mono) begin
      color.r = entry[7:0];
      color.g = entry[7:0];
      color.b = entry[7:0];
    end
  end
endmodule

// File: rtl/clut_sweep.sv
module clut_sweep #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W:0]   n_entries,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic             busy
);
  localparam int CNT_W = IDX_W + 1;

  logic             run_q;
  logic             pend_q;
  logic [CNT_W-1:0] rd_q;
  logic [IDX_W-1:0] wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      rd_q   <= '0;
      wr_q   <= '0;
    end else begin
      pend_q <= run_q;
      wr_q   <= rd_q[IDX_W-1:0];
      if (start) begin
        run_q <= 1'b1;
        rd_q  <= '0;
      end else if (run_q) begin
        rd_q <= rd_q + 1'b1;
        if (rd_q == n_entries - 1'b1) run_q <= 1'b0;
      end
    end
  end

  assign rd_en   = run_q;
  assign rd_addr = rd_q[IDX_W-1:0];
  assign wr_en   = pend_q;
  assign wr_addr = wr_q;
  assign busy    = run_q | pend_q;
endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_start,
  input  logic [3:0]       depth,
  input  logic [1:0]       fmt,
  input  logic             mono,
  input  logic             in_valid,
  input  logic [31:0]      in_entry,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [23:0]      lk_rgb,
  output logic             lk_trans,
  output logic             busy
);
  localparam int NUM   = 1 << IDX_W;
  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] limit_q, cnt_q;
  logic [1:0]       fmt_used_q;
  logic             accept_ld, accept_in, sweep_go;
  logic             sw_rd_en, sw_wr_en;
  logic [IDX_W-1:0] sw_rd_addr, sw_wr_addr;
  logic [31:0]      raw_q;
  logic [31:0]      cv_in;
  logic [1:0]       cv_fmt;
  clut_color_t      cv_out, lk_q;
  logic [COLOR_W-1:0] lk_raw;
  logic             conv_we;
  logic [IDX_W-1:0] conv_wa;

  function automatic logic [CNT_W-1:0] clamp_limit(input logic [3:0] d);
    int e;
    e = clut_entries(d);
    if (e > NUM) e = NUM;
    return CNT_W'(e);
  endfunction

  assign accept_ld = load_start & ~busy;
  assign accept_in = in_valid & ~busy & ~load_start & (cnt_q < limit_q);
  assign sweep_go  = ~busy & ~in_valid & ~load_start & (fmt != fmt_used_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q    <= '0;
      cnt_q      <= '0;
      fmt_used_q <= 2'd0;
    end else begin
      if (accept_ld) begin
        limit_q <= clamp_limit(depth);
        cnt_q   <= '0;
      end else if (accept_in) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (sweep_go) fmt_used_q <= fmt;
    end
  end

  clut_sweep #(.IDX_W(IDX_W)) u_sweep (
    .clk(clk), .rst(rst),
    .start(sweep_go && (cnt_q != '0)),
    .n_entries(cnt_q),
    .rd_en(sw_rd_en), .rd_addr(sw_rd_addr),
    .wr_en(sw_wr_en), .wr_addr(sw_wr_addr),
    .busy(busy)
  );

  clut_ram #(.AW(IDX_W), .DW(32)) u_raw (
    .clk(clk), .rst(rst),
    .we(accept_in), .wa(cnt_q[IDX_W-1:0]), .wd(in_entry),
    .re(sw_rd_en), .ra(sw_rd_addr), .rq(raw_q)
  );

  // stream writes and sweep writes never coincide: stream needs !busy
  assign cv_in   = sw_wr_en ? raw_q : in_entry;
  assign cv_fmt  = sw_wr_en ? fmt_used_q : fmt;
  assign conv_we = sw_wr_en | accept_in;
  assign conv_wa = sw_wr_en ? sw_wr_addr : cnt_q[IDX_W-1:0];

  clut_convert u_conv (.entry(cv_in), .fmt(cv_fmt), .mono(mono), .color(cv_out));

  clut_ram #(.AW(IDX_W), .DW(COLOR_W)) u_table (
    .clk(clk), .rst(rst),
    .we(conv_we), .wa(conv_wa), .wd(cv_out),
    .re(1'b1), .ra(lk_idx), .rq(lk_raw)
  );

  assign lk_q     = clut_color_t'(lk_raw);
  assign lk_rgb   = {lk_q.r, lk_q.g, lk_q.b};
  assign lk_trans = lk_q.trans;
endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk #(
  parameter int IDX_W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           in_valid,
  input logic           load_start,
  input logic [1:0]     fmt,
  input logic [1:0]     fmt_used,
  input logic [IDX_W:0] cnt,
  input logic [IDX_W:0] limit
);
  a_r1_idle_after_reset: assert property (@(posedge clk) rst |=> !busy);

  a_r2_count_within_limit: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);

  a_r2_limit_power: assert property (@(posedge clk) disable iff (rst)
    $onehot0(limit));

  a_r10_frozen_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cnt) && $stable(limit)));

  a_r9_sweep_starts: assert property (@(posedge clk) disable iff (rst)
    (!busy && !in_valid && !load_start && fmt != fmt_used && cnt != '0) |=> busy);

  a_r9_empty_no_sweep: assert property (@(posedge clk) disable iff (rst)
    (!busy && cnt == '0) |=> !busy);
endmodule

bind clut_loader clut_loader_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .in_valid(in_valid),
  .load_start(load_start), .fmt(fmt), .fmt_used(fmt_used_q),
  .cnt(cnt_q), .limit(limit_q)
);

// File: tb/test_clut_loader.sv
`timescale 1ns/1ps
module test_clut_loader;
  localparam int IDX_W = 8;
  localparam int NUM   = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ls = 1'b0;
  logic [3:0] dep = 4'd0;
  logic [1:0] fm = 2'd0;
  logic mn = 1'b0;
  logic iv = 1'b0;
  logic [31:0] ie = '0;
  logic [IDX_W-1:0] li = '0;
  logic [23:0] lk_rgb;
  logic lk_trans;
  logic busy;

  always #2.5 clk = ~clk;

  clut_loader #(.IDX_W(IDX_W)) i_clut_loader (
    .clk(clk), .rst(rst), .load_start(ls), .depth(dep), .fmt(fm), .mono(mn),
    .in_valid(iv), .in_entry(ie), .lk_idx(li),
    .lk_rgb(lk_rgb), .lk_trans(lk_trans), .busy(busy)
  );

  int compared = 0;
  int mismatched = 0;
  string cur = "R1";

  // reference model
  bit [31:0] m_raw  [NUM];
  bit [24:0] m_conv [NUM];
  bit        m_vld  [NUM];
  int m_cnt = 0, m_lim = 0, m_fmt_used = 0, m_busy_left = 0;

  function automatic bit [24:0] ref_cv(bit [31:0] e, int f, bit m);
    int r, g, b; bit t;
    if (f == 2) begin
      r = int'(e >> 16) & 'hf8; g = int'(e >> 8) & 'hfc; b = int'(e) & 'hf8;
    end else if (f == 3) begin
      r = int'(e >> 16) & 'hff; g = int'(e >> 8) & 'hff; b = int'(e) & 'hff;
    end else begin
      r = int'(e >> 8) & 'hf8; g = int'(e >> 3) & 'hfc; b = int'(e << 3) & 'hf8;
    end
    t = (f == 0) ? 1'b0 : e[24];
    if (m) begin r = int'(e) & 'hff; g = r; b = r; end
    return {t, r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic int ref_lim(int d);
    if (d == 1) return 4;
    if (d == 2) return 16;
    if (d == 3) return 256;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: inputs are already driven (at negedge)
  task automatic tick();
    bit [24:0] exp_lk;
    bit cmp_lk, bsy;
    exp_lk = m_conv[li];
    cmp_lk = m_vld[li] && (m_busy_left == 0);
    @(posedge clk);
    bsy = (m_busy_left > 0);
    if (bsy) m_busy_left--;
    if (!bsy) begin
      if (ls) begin
        m_lim = ref_lim(int'(dep)); m_cnt = 0;
      end else if (iv && m_cnt < m_lim) begin
        m_raw[m_cnt] = ie; m_conv[m_cnt] = ref_cv(ie, int'(fm), mn);
        m_vld[m_cnt] = 1'b1; m_cnt++;
      end
      if (!iv && !ls && int'(fm) != m_fmt_used) begin
        m_fmt_used = int'(fm);
        if (m_cnt > 0) begin
          for (int i = 0; i < m_cnt; i++) m_conv[i] = ref_cv(m_raw[i], int'(fm), mn);
          m_busy_left = m_cnt + 1;
        end
      end
    end
    #1;
    check({cur, " busy"}, int'(busy), int'(m_busy_left > 0));
    if (cmp_lk) check({cur, " lookup"}, int'({lk_trans, lk_rgb}), int'(exp_lk));
    @(negedge clk);
  endtask

  task automatic idle(int n);
    iv = 1'b0; ls = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic load(int d, int n);
    ls = 1'b1; dep = d[3:0]; tick(); ls = 1'b0;
    for (int i = 0; i < n; i++) begin
      iv = 1'b1; ie = $urandom;
      li = IDX_W'((m_cnt < NUM) ? m_cnt : NUM - 1);  // R8: read the slot being written
      tick();
    end
    iv = 1'b0;
  endtask

  task automatic scan(int n);
    for (int i = 0; i < n; i++) begin li = IDX_W'(i); tick(); end
  endtask

  initial begin
    for (int i = 0; i < NUM; i++) begin m_vld[i] = 0; m_raw[i] = 0; m_conv[i] = 0; end
    @(negedge clk);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset values observed at the ports
    check("R1 busy", int'(busy), 0);
    check("R1 rgb", int'(lk_rgb), 0);
    check("R1 trans", int'(lk_trans), 0);

    cur = "R6/R8/R11"; fm = 2'd3; load(3, 256);
    cur = "R6"; idle(1); scan(256);
    cur = "R2"; load(1, 6); idle(1); scan(8);
    cur = "R2"; load(0, 3); idle(1); scan(6);
    cur = "R9";  fm = 2'd1; idle(3);            // empty table: no busy
    cur = "R4/R8"; load(2, 16); idle(1); scan(20);
    cur = "R9/R3"; fm = 2'd0; idle(1);
    cur = "R10";
    for (int i = 0; i < 12; i++) begin
      iv = 1'b1; ie = $urandom; ls = (i % 3 == 0); dep = 4'd3; li = IDX_W'(i); tick();
    end
    iv = 1'b0; ls = 1'b0;
    cur = "R3/R9"; idle(10); scan(20);
    cur = "R5"; fm = 2'd2; idle(20); scan(20);
    cur = "R7"; mn = 1'b1; load(2, 16); idle(1); scan(16);
    fm = 2'd3; idle(20); scan(16);
    fm = 2'd0; idle(20); scan(16);
    mn = 1'b0;
    cur = "R5/R11"; fm = 2'd2; load(1, 4); idle(2); scan(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule